// File: doc/BRIEF.md
# Absolute-Indexed Bus-Cycle Sequencer

This block generates the bus activity of an 8-bit processor executing one instruction in absolute-indexed addressing mode. A start pulse loads the program counter, the access class, the index value, a modify code and the data to store. The block then fetches the opcode and the two operand address bytes itself. It forms the effective address and issues exactly the bus cycles such an instruction produces, including the dummy read cycles.

Memory is modelled as same-cycle: the address and read/write strobe are driven during a cycle, and read data must be valid on `rdData` before the clock edge that closes that cycle. Three access classes are supported: read, write and read-modify-write. Reads pay one extra cycle only when the index addition carries out of the low byte. Writes and read-modify-writes always issue a read at the uncorrected address before they write. Read-modify-write writes the original value back once before it writes the modified value.

Top module: `idxAddrSeq`

## Requirements
- R1: After reset, `cycleNum` is 0, `done` is 0, `rwRead` is 1 and `addr` is 0.
- R2: Bus cycles 1, 2 and 3 are reads at PC, PC+1 and PC+2. Cycle 2 returns the address low byte and cycle 3 the high byte.
- R3: Read class (`accClass` 0, and also 3) with no carry from low byte plus index takes 4 bus cycles. Cycle 4 reads the effective address, and the value read appears on `resultData`.
- R4: Read class with a carry takes 5 bus cycles. Cycle 4 reads {high byte, (low+index) mod 256}, and cycle 5 reads the effective address.
- R5: Write class (`accClass` 1) always takes 5 cycles. Cycle 4 reads {high byte, (low+index) mod 256}. Cycle 5 writes `storeData` to the effective address with `rwRead` 0. No write occurs before cycle 5.
- R6: Read-modify-write class (`accClass` 2) takes 7 cycles. Cycle 4 is the uncorrected read, cycle 5 reads the effective address, and cycle 6 writes back the unmodified value. Cycle 7 writes the modified value to the same address.
- R7: Modify codes: 0 increments and 1 decrements, both modulo 256. Code 2 shifts left and code 3 shifts right, each filling with zero. The modified value also appears on `resultData`.
- R8: The effective address is {high,low} plus the zero-extended index, modulo 65536.
- R9: `done` is high for exactly one cycle after the last bus cycle. During that cycle `cycleNum` is 0 and `rwRead` is 1.
- R10: A start while `cycleNum` is nonzero is ignored. The running sequence continues unchanged.
- R11: `cycleNum` shows the current bus cycle number and steps by one from 1 up to the last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence when idle |
| accClass | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 read |
| basePc | input | 16 | Address of the opcode |
| indexVal | input | 8 | Index register value |
| modOp | input | 2 | Modify code for read-modify-write |
| storeData | input | 8 | Data stored by the write class |
| rdData | input | 8 | Memory read data for the current cycle |
| addr | output | 16 | Bus address |
| rwRead | output | 1 | 1 = read cycle, 0 = write cycle |
| wrData | output | 8 | Write data |
| cycleNum | output | 3 | Current bus cycle number, 0 when idle |
| done | output | 1 | One-cycle completion pulse |
| resultData | output | 8 | Value read (read), modified value (RMW), stored value (write) |

## Verification
Cycle 1 appears on the bus in the first cycle after the edge that samples `start`. Bus cycle n is visible n cycles after that edge, and `done` together with `resultData` follows one cycle after the final bus cycle. The bench builds the expected list of bus cycles from the memory contents and the inputs before each start. It then compares `cycleNum`, `addr`, `rwRead` and, on writes, `wrData` at the falling edge of each cycle in turn. The completion pulse is checked at the falling edge one cycle after the last entry in the list.

// File: rtl/idxSeqPkg.sv
package idxSeqPkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int CYC_W  = 3;

  typedef enum logic [1:0] {ASEL_NONE, ASEL_PC, ASEL_DUMMY, ASEL_EA} addrSel_t;

  typedef struct packed {
    logic     loadStart;
    logic     pcInc;
    logic     latchLo;
    logic     latchHi;
    logic     latchData;
    logic     latchMod;
    logic     wrEn;
    addrSel_t addrSel;
  } dpCtl_t;
endpackage

// File: rtl/idxSeqCtrl.sv
module idxSeqCtrl
  import idxSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       accClass,
  input  logic             pageCross,
  output dpCtl_t           ctl,
  output logic [CYC_W-1:0] cycleNum,
  output logic             done
);
  logic [CYC_W-1:0] cyc;
  logic [1:0]       clsReg;
  logic             doneQ;
  logic             lastCyc;
  logic             isWr, isRmw, isRd;

  assign isWr  = (clsReg == 2'd1);
  assign isRmw = (clsReg == 2'd2);
  assign isRd  = !isWr && !isRmw;

  always_comb begin
    ctl = '0;
    ctl.addrSel = ASEL_NONE;
    lastCyc = 1'b0;
    ctl.loadStart = (cyc == '0) && start;
    case (cyc)
      3'd1: begin ctl.addrSel = ASEL_PC; ctl.pcInc = 1'b1; end
      3'd2: begin ctl.addrSel = ASEL_PC; ctl.pcInc = 1'b1; ctl.latchLo = 1'b1; end
      3'd3: begin ctl.addrSel = ASEL_PC; ctl.latchHi = 1'b1; end
      3'd4: begin
        if (isRd && !pageCross) begin
          ctl.addrSel = ASEL_EA; ctl.latchData = 1'b1; lastCyc = 1'b1;
        end else begin
          ctl.addrSel = ASEL_DUMMY;
        end
      end
      3'd5: begin
        ctl.addrSel = ASEL_EA;
        if (isWr) begin ctl.wrEn = 1'b1; lastCyc = 1'b1; end
        else begin
          ctl.latchData = 1'b1;
          lastCyc = isRd;
        end
      end
      3'd6: begin ctl.addrSel = ASEL_EA; ctl.wrEn = 1'b1; ctl.latchMod = 1'b1; end
      3'd7: begin ctl.addrSel = ASEL_EA; ctl.wrEn = 1'b1; lastCyc = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cyc    <= '0;
      clsReg <= 2'd0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (cyc == '0) begin
        if (start) begin
          cyc    <= 3'd1;
          clsReg <= accClass;
        end
      end else if (lastCyc) begin
        cyc   <= '0;
        doneQ <= 1'b1;
      end else begin
        cyc <= cyc + 3'd1;
      end
    end
  end

  assign cycleNum = cyc;
  assign done     = doneQ;
endmodule

// File: rtl/idxSeqDp.sv
module idxSeqDp
  import idxSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] basePc,
  input  logic [DATA_W-1:0] indexVal,
  input  logic [1:0]        modOp,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] rdData,
  output logic              pageCross,
  output logic [ADDR_W-1:0] addr,
  output logic              rwRead,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] resultData
);
  logic [ADDR_W-1:0] pcReg;
  logic [DATA_W-1:0] idxReg, loReg, hiReg, dataReg, modResult;
  logic [1:0]        opReg;
  logic [DATA_W:0]   lowSum;
  logic [ADDR_W-1:0] effAddr, dummyAddr;

  assign lowSum    = {1'b0, loReg} + {1'b0, idxReg};
  assign pageCross = lowSum[DATA_W];
  assign dummyAddr = {hiReg, lowSum[DATA_W-1:0]};
  assign effAddr   = {hiReg, loReg} + {{(ADDR_W-DATA_W){1'b0}}, idxReg};

  always_comb begin
    case (opReg)
      2'd0:    modResult = dataReg + 8'd1;
      2'd1:    modResult = dataReg - 8'd1;
      2'd2:    modResult = {dataReg[DATA_W-2:0], 1'b0};
      default: modResult = {1'b0, dataReg[DATA_W-1:1]};
    endcase
  end

  always_comb begin
    case (ctl.addrSel)
      ASEL_PC:    addr = pcReg;
      ASEL_DUMMY: addr = dummyAddr;
      ASEL_EA:    addr = effAddr;
      default:    addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg   <= '0;
      idxReg  <= '0;
      loReg   <= '0;
      hiReg   <= '0;
      dataReg <= '0;
      opReg   <= 2'd0;
    end else begin
      if (ctl.loadStart) begin
        pcReg   <= basePc;
        idxReg  <= indexVal;
        opReg   <= modOp;
        dataReg <= storeData;
      end
      if (ctl.pcInc)     pcReg   <= pcReg + 16'd1;
      if (ctl.latchLo)   loReg   <= rdData;
      if (ctl.latchHi)   hiReg   <= rdData;
      if (ctl.latchData) dataReg <= rdData;
      if (ctl.latchMod)  dataReg <= modResult;
    end
  end

  assign rwRead     = !ctl.wrEn;
  assign wrData     = dataReg;
  assign resultData = dataReg;
endmodule

// File: rtl/idxAddrSeq.sv
module idxAddrSeq
  import idxSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        accClass,
  input  logic [ADDR_W-1:0] basePc,
  input  logic [DATA_W-1:0] indexVal,
  input  logic [1:0]        modOp,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] addr,
  output logic              rwRead,
  output logic [DATA_W-1:0] wrData,
  output logic [CYC_W-1:0]  cycleNum,
  output logic              done,
  output logic [DATA_W-1:0] resultData
);
  dpCtl_t ctl;
  logic   pageCross;

  idxSeqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .accClass(accClass),
    .pageCross(pageCross), .ctl(ctl), .cycleNum(cycleNum), .done(done)
  );

  idxSeqDp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .basePc(basePc), .indexVal(indexVal),
    .modOp(modOp), .storeData(storeData), .rdData(rdData),
    .pageCross(pageCross), .addr(addr), .rwRead(rwRead), .wrData(wrData),
    .resultData(resultData)
  );
endmodule

// File: rtl/idxSeqChk.sv
module idxSeqChk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic [15:0] addr,
  input logic        rwRead,
  input logic [2:0]  cycleNum,
  input logic        done
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rwRead && cycleNum == 3'd0)); // R9
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cycleNum != 3'd0) |=> ((cycleNum == $past(cycleNum) + 3'd1) || done)); // R11
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (cycleNum != 3'd0 && start) |=> (cycleNum != 3'd1)); // R10
  AST_WRITE_LATE: assert property (@(posedge clk) disable iff (!rstN)
    !rwRead |-> (cycleNum >= 3'd5)); // R5
  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    (!rwRead && cycleNum == 3'd5) |-> $past(rwRead)); // R5
  AST_RMW_SAME_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (!rwRead && cycleNum == 3'd7) |-> (addr == $past(addr) && !$past(rwRead))); // R6
  AST_FETCH_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (cycleNum == 3'd2) |-> (addr == $past(addr) + 16'd1)); // R2
endmodule

bind idxAddrSeq idxSeqChk u_chk (.*);

// File: tb/sim_idxAddrSeq.sv
module sim_idxAddrSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  accClass = 2'd0;
  logic [15:0] basePc = '0;
  logic [7:0]  indexVal = '0;
  logic [1:0]  modOp = 2'd0;
  logic [7:0]  storeData = '0;
  logic [7:0]  rdData;
  logic [15:0] addr;
  logic        rwRead;
  logic [7:0]  wrData;
  logic [2:0]  cycleNum;
  logic        done;
  logic [7:0]  resultData;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign rdData = memf(addr);

  idxAddrSeq u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] modf(input logic [1:0] op, input logic [7:0] v);
    case (op)
      2'd0: return v + 8'd1;
      2'd1: return v - 8'd1;
      2'd2: return v << 1;
      default: return v >> 1;
    endcase
  endfunction

  task automatic runSeq(input logic [1:0] cls, input logic [15:0] pc, input logic [7:0] idx,
                        input logic [1:0] op, input logic [7:0] sd, input int glitchAt,
                        input string pre);
    logic [15:0] qa[$];
    bit          qr[$];
    logic [7:0]  qd[$];
    string       qt[$];
    logic [7:0]  lo, hi, res;
    logic [8:0]  sum9;
    logic [15:0] ea, dum;
    lo   = memf(pc + 16'd1);
    hi   = memf(pc + 16'd2);
    sum9 = {1'b0, lo} + {1'b0, idx};
    dum  = {hi, sum9[7:0]};
    ea   = {hi, lo} + {8'h00, idx};
    qa.push_back(pc);         qr.push_back(1); qd.push_back(0); qt.push_back("R2");
    qa.push_back(pc + 16'd1); qr.push_back(1); qd.push_back(0); qt.push_back("R2");
    qa.push_back(pc + 16'd2); qr.push_back(1); qd.push_back(0); qt.push_back("R2");
    if (cls == 2'd1) begin
      qa.push_back(dum); qr.push_back(1); qd.push_back(0);  qt.push_back("R5");
      qa.push_back(ea);  qr.push_back(0); qd.push_back(sd); qt.push_back("R5/R8");
      res = sd;
    end else if (cls == 2'd2) begin
      qa.push_back(dum); qr.push_back(1); qd.push_back(0); qt.push_back("R6");
      qa.push_back(ea);  qr.push_back(1); qd.push_back(0); qt.push_back("R6/R8");
      qa.push_back(ea);  qr.push_back(0); qd.push_back(memf(ea)); qt.push_back("R6");
      res = modf(op, memf(ea));
      qa.push_back(ea);  qr.push_back(0); qd.push_back(res); qt.push_back("R7");
    end else begin
      if (sum9[8]) begin
        qa.push_back(dum); qr.push_back(1); qd.push_back(0); qt.push_back("R4");
      end
      qa.push_back(ea); qr.push_back(1); qd.push_back(0);
      qt.push_back(sum9[8] ? "R4/R8" : "R3/R8");
      res = memf(ea);
    end
    @(negedge clk);
    start = 1'b1; accClass = cls; basePc = pc; indexVal = idx; modOp = op; storeData = sd;
    for (int i = 0; i < qa.size(); i++) begin
      @(negedge clk);
      start = (glitchAt == i + 1);
      if (glitchAt == i + 1) begin
        accClass = 2'd0; basePc = pc ^ 16'h1234; indexVal = idx + 8'd7; storeData = ~sd;
      end
      chk(cycleNum == 3'(i + 1), {pre, "R11 cycleNum"}, cycleNum, i + 1);
      chk(addr == qa[i], {pre, qt[i], " addr"}, addr, qa[i]);
      chk(rwRead == qr[i], {pre, qt[i], " rwRead"}, rwRead, qr[i]);
      if (!qr[i]) chk(wrData == qd[i], {pre, qt[i], " wrData"}, wrData, qd[i]);
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, {pre, "R9 done"}, done, 1);
    chk(cycleNum == 3'd0 && rwRead, {pre, "R9 quiet"}, {cycleNum, rwRead}, 1);
    chk(resultData == res, {pre, qt[qt.size() - 1], " resultData"}, resultData, res);
    @(negedge clk);
    chk(done == 1'b0, {pre, "R9 single pulse"}, done, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk(cycleNum == 3'd0 && !done, "R1 idle", {cycleNum, done}, 0);
    chk(rwRead && addr == 16'h0, "R1 bus", {rwRead, addr}, 17'h10000);
    runSeq(2'd0, 16'h0310, 8'h00, 2'd0, 8'h00, 0, "");
    runSeq(2'd0, 16'h0310, 8'hFF, 2'd0, 8'h00, 0, "");
    runSeq(2'd3, 16'h1200, 8'h11, 2'd0, 8'h00, 0, "");
    runSeq(2'd1, 16'h0400, 8'h00, 2'd0, 8'hC3, 0, "");
    runSeq(2'd1, 16'h0400, 8'hFF, 2'd0, 8'h3C, 0, "");
    runSeq(2'd2, 16'h0520, 8'h04, 2'd0, 8'h00, 0, "");
    runSeq(2'd2, 16'h0520, 8'hF0, 2'd1, 8'h00, 0, "");
    runSeq(2'd2, 16'h0644, 8'h21, 2'd2, 8'h00, 0, "");
    runSeq(2'd2, 16'h0644, 8'h99, 2'd3, 8'h00, 0, "");
    runSeq(2'd0, 16'h00A3, 8'h05, 2'd0, 8'h00, 0, "R8 wrap ");
    runSeq(2'd2, 16'h00A3, 8'h05, 2'd0, 8'h00, 0, "R8 wrap ");
    runSeq(2'd2, 16'h0700, 8'h80, 2'd0, 8'h00, 3, "R10 ");
    runSeq(2'd1, 16'h0800, 8'h01, 2'd0, 8'h5A, 5, "R10 ");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule